// File: doc/BRIEF.md
# Sampling Converter Serial Port Model

This block reproduces, in synthesizable logic, the digital side of a sampling converter's three-wire serial port. A host controller drives a conversion-start strobe and a serial clock. The block answers on a single data line. It is meant to stand in for the real converter when host-side controllers are tested. A parallel sample word on `sample_i` takes the place of the analog result and is captured at the moment a conversion is accepted.

All logic runs on a fast system clock. The strobe and serial clock pins are synchronized and edge-detected, so every rule below refers to a rising edge as it is seen after the synchronizer. A frame lasts a fixed number of serial clock rising edges. While a frame is in progress, further start strobes cannot open a new frame. The word leaves MSB first after a fixed number of lead edges.

A separate counter watches for start strobes that arrive with no serial clock activity between them. Two such strobes in a row send the model into a light power-down state, and four send it into a deep one. Any serial clock rising edge wakes it again.

Top module: `sconv_port_model`

## Requirements
- R1: A strobe rising edge seen while no frame is open opens a frame and captures `sample_i` as the word to send.
- R2: While a frame is open, strobe rising edges have no effect on the data being sent. The frame closes on its 16th serial clock rising edge, and only after that can a strobe open a new frame.
- R3: Counting serial clock rising edges of the frame from 1, edge n = 3 puts word bit DATA_W-1 on `sdo_o`. Each later edge puts out the next lower bit, down to bit 0 at edge n = DATA_W+2.
- R4: `sdo_o` is 0 from the opening of a frame until edge 3. It is also 0 after every edge past n = DATA_W+2 within the frame. Out of reset it is 0. It changes only at a serial clock edge of an open frame or at the opening of a frame.
- R5: The whole word leaves within the frame: only DATA_W of 12 or 14 is accepted, and lead edges plus DATA_W may not exceed the 16 edges of a frame.
- R6: Two strobe rising edges with no serial clock rising edge between them set `pwr_state_o` to nap (code 1).
- R7: Four such strobe edges set `pwr_state_o` to sleep (code 2). Further strobe edges keep it at sleep.
- R8: Any serial clock rising edge sets `pwr_state_o` to active (code 0) and restarts the strobe count from zero, whatever the frame state.
- R9: After reset `pwr_state_o` is active (code 0), `sdo_o` is 0 and no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_i | input | 1 | Conversion-start strobe pin, asynchronous |
| sck_i | input | 1 | Serial clock pin, asynchronous |
| sample_i | input | DATA_W | Word captured when a frame opens |
| sdo_o | output | 1 | Serial data, MSB first |
| pwr_state_o | output | 2 | Power state: 0 active, 1 nap, 2 sleep |

## Verification
The bench builds two copies side by side from the same pins, one with a 12-bit word and one with a 14-bit word. Both use the default two-stage synchronizer and a 16-edge frame. With the 12-bit copy, the trailing zero edges 15 and 16 can be checked. With the 14-bit copy, the last bit lands exactly on the closing edge. In that case a strobe ignored at edge 15 must not disturb bit 0, and the next strobe must then open a fresh frame.

// File: rtl/sconv_pkg.sv
package sconv_pkg;

   // Power state codes, seen at the pwr_state_o port
   typedef enum logic [1:0] {
      PWR_ACTIVE = 2'd0,
      PWR_NAP    = 2'd1,
      PWR_SLEEP  = 2'd2
   } pwr_e;

   // Frame owns this many serial clock edges
   localparam int unsigned FRAME_EDGES_DEF = 16;
   // Edges before the first data bit
   localparam int unsigned LEAD_EDGES_DEF  = 2;

endpackage

// File: rtl/sconv_edge_sync.sv
module sconv_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o
);

   logic [STAGES:0] chain;
   logic            prev_q;

   assign chain[0] = pin_i;

   // One flop per stage; STAGES = 0 gives a direct path
   for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[gi+1] <= 1'b0;
         else        chain[gi+1] <= chain[gi];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain[STAGES];
   end

   assign rise_o = chain[STAGES] & ~prev_q;

   // a rise is one cycle wide
   assert_rise_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/sconv_frame.sv
module sconv_frame #(
   parameter int unsigned DATA_W      = 12,
   parameter int unsigned FRAME_EDGES = 16,
   parameter int unsigned LEAD_EDGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_rise,
   input  logic              sck_rise,
   input  logic [DATA_W-1:0] sample_i,
   output logic              sdo_o
);

   localparam int unsigned CNT_W = $clog2(FRAME_EDGES + 1);
   localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(FRAME_EDGES);
   localparam logic [CNT_W-1:0] LEAD_C  = CNT_W'(LEAD_EDGES);
   localparam logic [CNT_W-1:0] FINAL_C = CNT_W'(LEAD_EDGES + DATA_W);

   logic              busy_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_nx;
   logic [DATA_W-1:0] shreg_q;
   logic              sdo_q;
   logic              data_edge;

   assign cnt_nx    = cnt_q + 1'b1;
   assign data_edge = (cnt_nx > LEAD_C) && (cnt_nx <= FINAL_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         cnt_q   <= '0;
         shreg_q <= '0;
         sdo_q   <= 1'b0;
      end else if (!busy_q && conv_rise) begin
         busy_q  <= 1'b1;
         cnt_q   <= '0;
         shreg_q <= sample_i;
         sdo_q   <= 1'b0;
      end else if (busy_q && sck_rise) begin
         cnt_q <= cnt_nx;
         if (cnt_nx == LAST_C) busy_q <= 1'b0;
         if (data_edge) begin
            sdo_q   <= shreg_q[DATA_W-1];
            shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
         end else begin
            sdo_q <= 1'b0;
         end
      end
   end

   assign sdo_o = sdo_q;

   // strobe during an open frame leaves frame progress untouched
   assert_conv_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && conv_rise && !sck_rise) |=> (busy_q && $stable(cnt_q) && $stable(shreg_q)));

   // edge count never passes the frame length
   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST_C);

   // quiet line during lead edges
   assert_lead_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q <= LEAD_C) |-> !sdo_q);

   // quiet line after the last bit
   assert_tail_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q > FINAL_C) |-> !sdo_q);

   // no serial clock, no strobe: line holds
   assert_sdo_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sck_rise && !conv_rise) |=> $stable(sdo_q));

endmodule

// File: rtl/sconv_power.sv
module sconv_power
   import sconv_pkg::*;
#(
   parameter int unsigned NAP_EDGES   = 2,
   parameter int unsigned SLEEP_EDGES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic conv_rise,
   input  logic sck_rise,
   output pwr_e pwr_o
);

   localparam int unsigned PW_W = $clog2(SLEEP_EDGES + 1);
   localparam logic [PW_W-1:0] NAP_C   = PW_W'(NAP_EDGES);
   localparam logic [PW_W-1:0] SLEEP_C = PW_W'(SLEEP_EDGES);

   logic [PW_W-1:0] cnt_q;
   logic [PW_W-1:0] cnt_sat;
   pwr_e            pwr_q;

   // saturating count of strobes seen since the last serial clock edge
   assign cnt_sat = (cnt_q == SLEEP_C) ? cnt_q : cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pwr_q <= PWR_ACTIVE;
      end else if (sck_rise) begin
         cnt_q <= '0;
         pwr_q <= PWR_ACTIVE;
      end else if (conv_rise) begin
         cnt_q <= cnt_sat;
         if (cnt_sat >= SLEEP_C)    pwr_q <= PWR_SLEEP;
         else if (cnt_sat >= NAP_C) pwr_q <= PWR_NAP;
      end
   end

   assign pwr_o = pwr_q;

   // serial clock edge always wakes
   assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sck_rise |=> (pwr_q == PWR_ACTIVE));

   // no strobe-only sequence ever goes back up the ladder
   assert_no_lighter_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_rise && !sck_rise && pwr_q == PWR_NAP) |=> (pwr_q != PWR_ACTIVE));

   // sleep is kept while only strobes arrive
   assert_sleep_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sck_rise && pwr_q == PWR_SLEEP) |=> (pwr_q == PWR_SLEEP));

   // only three legal codes
   assert_code_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_q != 2'd3);

endmodule

// File: rtl/sconv_port_model.sv
module sconv_port_model
   import sconv_pkg::*;
#(
   parameter int unsigned DATA_W      = 12,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FRAME_EDGES = FRAME_EDGES_DEF,
   parameter int unsigned LEAD_EDGES  = LEAD_EDGES_DEF,
   parameter int unsigned NAP_EDGES   = 2,
   parameter int unsigned SLEEP_EDGES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_i,
   input  logic              sck_i,
   input  logic [DATA_W-1:0] sample_i,
   output logic              sdo_o,
   output logic [1:0]        pwr_state_o
);

   // elaboration checks (R5 and power ladder)
   if (DATA_W != 12 && DATA_W != 14) begin : g_bad_width_R5
      $error("DATA_W must be 12 or 14");
   end
   if (LEAD_EDGES + DATA_W > FRAME_EDGES) begin : g_bad_frame_R5
      $error("word does not fit in the frame");
   end
   if (NAP_EDGES < 1 || NAP_EDGES >= SLEEP_EDGES) begin : g_bad_ladder
      $error("NAP_EDGES must be at least 1 and below SLEEP_EDGES");
   end

   logic conv_rise;
   logic sck_rise;
   pwr_e pwr;

   sconv_edge_sync #(.STAGES(SYNC_STAGES)) u_conv_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (conv_i),
      .rise_o (conv_rise)
   );

   sconv_edge_sync #(.STAGES(SYNC_STAGES)) u_sck_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (sck_i),
      .rise_o (sck_rise)
   );

   sconv_frame #(
      .DATA_W      (DATA_W),
      .FRAME_EDGES (FRAME_EDGES),
      .LEAD_EDGES  (LEAD_EDGES)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .conv_rise (conv_rise),
      .sck_rise  (sck_rise),
      .sample_i  (sample_i),
      .sdo_o     (sdo_o)
   );

   sconv_power #(
      .NAP_EDGES   (NAP_EDGES),
      .SLEEP_EDGES (SLEEP_EDGES)
   ) u_power (
      .clk       (clk),
      .rst_n     (rst_n),
      .conv_rise (conv_rise),
      .sck_rise  (sck_rise),
      .pwr_o     (pwr)
   );

   assign pwr_state_o = pwr;

   // R9: idle outputs on the first cycle after reset release
   assert_reset_state_R9: assert property (@(posedge clk)
      $rose(rst_n) |-> (!sdo_o && pwr_state_o == 2'd0));

endmodule

// File: tb/sconv_port_model_tb_top.sv
module sconv_port_model_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv = 1'b0;
   logic        sck = 1'b0;
   logic [13:0] sample = '0;
   logic        sdo12, sdo14;
   logic [1:0]  pwr12, pwr14;
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   sconv_port_model #(.DATA_W(12)) dut_i (
      .clk(clk), .rst_n(rst_n), .conv_i(conv), .sck_i(sck),
      .sample_i(sample[11:0]), .sdo_o(sdo12), .pwr_state_o(pwr12));

   sconv_port_model #(.DATA_W(14)) dut14_i (
      .clk(clk), .rst_n(rst_n), .conv_i(conv), .sck_i(sck),
      .sample_i(sample), .sdo_o(sdo14), .pwr_state_o(pwr14));

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_bit(input logic [13:0] word, input int w, input int n);
      if (n >= 3 && n <= w + 2) return int'(word[w - 1 - (n - 3)]);
      return 0;
   endfunction

   task automatic wait_clk(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic sck_pulse();
      sck = 1'b1; wait_clk(4);
      sck = 1'b0; wait_clk(4);
   endtask

   task automatic conv_pulse();
      conv = 1'b1; wait_clk(4);
      conv = 1'b0; wait_clk(4);
   endtask

   // edges first..last of a frame, checking both copies
   task automatic run_edges(input logic [13:0] word, input int first, input int last,
                            input string req);
      for (int n = first; n <= last; n++) begin
         sck_pulse();
         check({req, " sdo12"}, int'(sdo12), exp_bit(word, 12, n));
         check({req, " sdo14"}, int'(sdo14), exp_bit(word, 14, n));
      end
   endtask

   task automatic t_reset();
      check("R9 sdo12", int'(sdo12), 0);
      check("R9 sdo14", int'(sdo14), 0);
      check("R9 pwr12", int'(pwr12), 0);
      check("R9 pwr14", int'(pwr14), 0);
   endtask

   // R1 R3 R4: plain frame
   task automatic t_frame(input logic [13:0] word);
      sample = word;
      conv_pulse();
      check("R4 lead sdo12", int'(sdo12), 0);
      check("R4 lead sdo14", int'(sdo14), 0);
      check("R8 single strobe pwr", int'(pwr12), 0);
      run_edges(word, 1, 16, "R3");
   endtask

   // R2: strobe at edge 15 ignored, next strobe opens a new frame
   task automatic t_block();
      logic [13:0] a = 14'h2A5C;
      logic [13:0] b = 14'h1B37;
      sample = a;
      conv_pulse();
      run_edges(a, 1, 5, "R2 pre");
      sample = b;
      conv_pulse();
      run_edges(a, 6, 15, "R2 mid");
      conv_pulse();
      check("R2 late strobe sdo14", int'(sdo14), exp_bit(a, 14, 15));
      run_edges(a, 16, 16, "R2 closing");
      conv_pulse();
      check("R1 new frame sdo12", int'(sdo12), 0);
      check("R1 new frame sdo14", int'(sdo14), 0);
      run_edges(b, 1, 16, "R1 word b");
   endtask

   // R6 R7 R8: power ladder
   task automatic t_power();
      logic [13:0] w = 14'h3FFF;
      sample = w;
      conv_pulse();
      check("R6 one strobe", int'(pwr12), 0);
      conv_pulse();
      check("R6 nap", int'(pwr12), 1);
      check("R6 nap 14", int'(pwr14), 1);
      conv_pulse();
      check("R6 third strobe", int'(pwr12), 1);
      conv_pulse();
      check("R7 sleep", int'(pwr12), 2);
      conv_pulse();
      check("R7 sleep held", int'(pwr14), 2);
      run_edges(w, 1, 1, "R2 after sleep");
      check("R8 wake", int'(pwr12), 0);
      check("R8 wake 14", int'(pwr14), 0);
      conv_pulse();
      check("R8 count cleared", int'(pwr12), 0);
      run_edges(w, 2, 16, "R3 all ones");
      conv_pulse();
      conv_pulse();
      check("R6 nap again", int'(pwr12), 1);
      sck_pulse();
      check("R8 wake from nap", int'(pwr12), 0);
      for (int n = 2; n <= 16; n++) sck_pulse();
   endtask

   initial begin
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(3);
      t_reset();
      t_frame(14'h2ABC);
      t_frame(14'h1555);
      t_frame(14'h0001);
      t_block();
      t_power();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule